// File: doc/BRIEF.md
# Audio Sample-Rate Tick Generator

This block turns a steady reference enable (one pulse per period of a 1.4112 MHz reference) into three sample-rate strobes: one for a first playback channel, one for a second playback channel and one for a record channel. The first playback channel runs from a fixed-ratio divider whose ratio is chosen by a 2-bit selector, giving the 44100 Hz family of rates (nominally 5512, 11025, 22050 and 44100 Hz). The record channel always runs from a programmable divider that divides the reference by the 13-bit setting plus two.

The second playback channel picks its strobe from one of three places: the programmable divider (default), the fixed-ratio divider when the follow bit is set, or an externally supplied serial-port clock strobe when the external-source bit is set and the follow bit is clear. Software converts a wanted rate into a divider setting; the block only divides.

Each strobe is a one-cycle pulse, produced only while that channel's enable is high. Divider settings are sampled only at period boundaries, so a reprogrammed rate never shortens or stretches the period already in progress.

Top module: `srate_tick_gen`

## Requirements
- R1: With `fixed_sel` = 0, 1, 2, 3 the first playback tick occurs once every 256, 128, 64, 32 reference pulses respectively.
- R2: The record tick occurs once every `div_n` + 2 reference pulses, for `div_n` from 0 to 8191.
- R3: With `follow_fixed` = 0 and `ext_src` = 0, the second playback tick occurs in the same cycles as the record tick (both enabled).
- R4: With `follow_fixed` = 1, the second playback tick occurs in the same cycles as the first playback tick, whatever `ext_src` is.
- R5: With `follow_fixed` = 0 and `ext_src` = 1, the second playback tick is `ext_tick` delayed by one clock, and the dividers do not produce second playback ticks.
- R6: A divided tick goes high in the clock cycle right after the reference pulse that ends a period; after reset the first tick follows the P-th reference pulse, where P is the period.
- R7: A change of `div_n` or `fixed_sel` does not affect the period in progress; the new period starts after the next tick boundary.
- R8: A tick output is high only while its enable was high in the previous cycle; the dividers keep counting while an output is disabled, so its phase is kept.
- R9: A divided tick is high for exactly one clock cycle.
- R10: During and right after reset all three tick outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One-cycle pulse at the 1.4112 MHz reference rate |
| ext_tick | input | 1 | External serial-port clock strobe |
| fixed_sel | input | 2 | First playback rate select (0 slowest, 3 fastest) |
| div_n | input | 13 | Programmable divider setting N, period N+2 |
| follow_fixed | input | 1 | Second playback follows the first playback rate |
| ext_src | input | 1 | Second playback takes the external strobe |
| play0_en | input | 1 | First playback tick enable |
| play1_en | input | 1 | Second playback tick enable |
| rec_en | input | 1 | Record tick enable |
| play0_tick | output | 1 | First playback sample strobe |
| play1_tick | output | 1 | Second playback sample strobe |
| rec_tick | output | 1 | Record sample strobe |

## Verification
Every tick is due exactly one clock after the reference pulse (or external strobe) that causes it, since the only register between the inputs and the outputs is the output flop. The bench drives each pulse on a falling edge, lets one rising edge pass and samples on the next falling edge, which is the one cycle where the tick is high; a per-cycle monitor on falling edges counts ticks and coincidence mismatches. Boundary and reprogramming tests count reference pulses from a reset so the period phase is known exactly.

// File: rtl/srate_tick_gen.sv
module srate_tick_gen #(
  parameter int DIV_W     = 13,
  parameter int SEL_W     = 2,
  parameter int FIX_LOG2  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic             ext_tick,
  input  logic [SEL_W-1:0] fixed_sel,
  input  logic [DIV_W-1:0] div_n,
  input  logic             follow_fixed,
  input  logic             ext_src,
  input  logic             play0_en,
  input  logic             play1_en,
  input  logic             rec_en,
  output logic             play0_tick,
  output logic             play1_tick,
  output logic             rec_tick
);

  localparam int FIX_W  = FIX_LOG2 + 1;
  localparam int PROG_W = DIV_W + 1;

  logic [FIX_W-1:0]  fix_period, fix_rem;
  logic [PROG_W-1:0] prog_period, prog_rem;
  logic              fix_hit, prog_hit, play1_src;

  assign fix_period  = FIX_W'(1) << (FIX_W'(FIX_LOG2) - FIX_W'(fixed_sel));
  assign prog_period = PROG_W'(div_n) + PROG_W'(2);

  assign fix_hit  = ref_en && (fix_rem == FIX_W'(1));
  assign prog_hit = ref_en && (prog_rem == PROG_W'(1));

  assign play1_src = follow_fixed ? fix_hit : (ext_src ? ext_tick : prog_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fix_rem <= '0;
    end else if (ref_en) begin
      if (fix_rem == '0)             fix_rem <= fix_period - FIX_W'(1);
      else if (fix_rem == FIX_W'(1)) fix_rem <= fix_period;
      else                           fix_rem <= fix_rem - FIX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_rem <= '0;
    end else if (ref_en) begin
      if (prog_rem == '0)              prog_rem <= prog_period - PROG_W'(1);
      else if (prog_rem == PROG_W'(1)) prog_rem <= prog_period;
      else                             prog_rem <= prog_rem - PROG_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      play0_tick <= 1'b0;
      play1_tick <= 1'b0;
      rec_tick   <= 1'b0;
    end else begin
      play0_tick <= fix_hit  && play0_en;
      play1_tick <= play1_src && play1_en;
      rec_tick   <= prog_hit && rec_en;
    end
  end

  // R6
  play0_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play0_tick |-> $past(ref_en));
  // R6
  rec_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_tick |-> $past(ref_en));
  // R8
  play0_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play0_tick |-> $past(play0_en));
  // R8
  play1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play1_tick |-> $past(play1_en));
  // R8
  rec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_tick |-> $past(rec_en));
  // R9
  play0_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play0_tick |=> !play0_tick);
  // R9
  rec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_tick |=> !rec_tick);
  // R4
  follow_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (follow_fixed && play0_en && play1_en) |=> (play1_tick == play0_tick));
  // R3
  prog_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!follow_fixed && !ext_src && rec_en && play1_en) |=> (play1_tick == rec_tick));
  // R5
  ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!follow_fixed && ext_src && play1_en) |=> (play1_tick == $past(ext_tick)));

endmodule

// File: tb/srate_tick_gen_bench.sv
module srate_tick_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b0, ext_tick = 1'b0;
  logic [1:0]  fixed_sel = '0;
  logic [12:0] div_n = '0;
  logic        follow_fixed = 1'b0, ext_src = 1'b0;
  logic        play0_en = 1'b0, play1_en = 1'b0, rec_en = 1'b0;
  logic        play0_tick, play1_tick, rec_tick;

  int errors = 0, checks = 0;
  int c0 = 0, c1 = 0, c2 = 0, mis_fix = 0, mis_prog = 0;

  always #5 clk = ~clk;

  srate_tick_gen u_srate_tick_gen (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .ext_tick(ext_tick),
    .fixed_sel(fixed_sel), .div_n(div_n), .follow_fixed(follow_fixed),
    .ext_src(ext_src), .play0_en(play0_en), .play1_en(play1_en),
    .rec_en(rec_en), .play0_tick(play0_tick), .play1_tick(play1_tick),
    .rec_tick(rec_tick));

  always @(negedge clk) begin
    c0 <= c0 + int'(play0_tick);
    c1 <= c1 + int'(play1_tick);
    c2 <= c2 + int'(rec_tick);
    mis_fix  <= mis_fix  + int'(play1_tick != play0_tick);
    mis_prog <= mis_prog + int'(play1_tick != rec_tick);
  end

  typedef struct packed {
    logic [1:0]  sel;
    logic [12:0] n;
    logic        sync;
    logic        ext;
    logic [2:0]  en;
    logic [13:0] pulses;
    logic [9:0]  e0, e1, e2;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 13'd0,    1'b0, 1'b0, 3'b111, 14'd64,   10'd2,   10'd32,  10'd32},
    '{2'd2, 13'd5,    1'b0, 1'b0, 3'b111, 14'd150,  10'd2,   10'd21,  10'd21},
    '{2'd1, 13'd30,   1'b1, 1'b0, 3'b111, 14'd300,  10'd2,   10'd2,   10'd9},
    '{2'd0, 13'd98,   1'b0, 1'b1, 3'b111, 14'd520,  10'd2,   10'd0,   10'd5},
    '{2'd3, 13'd1,    1'b0, 1'b0, 3'b010, 14'd90,   10'd0,   10'd30,  10'd0},
    '{2'd3, 13'd8191, 1'b0, 1'b0, 3'b111, 14'd8200, 10'd256, 10'd1,   10'd1},
    '{2'd2, 13'd3,    1'b1, 1'b1, 3'b111, 14'd130,  10'd2,   10'd2,   10'd26}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    c0 = 0; c1 = 0; c2 = 0; mis_fix = 0; mis_prog = 0;
  endtask

  // pulse ref_en for one cycle; on return the resulting tick is visible
  task automatic pulse_ref();
    ref_en = 1'b1;
    @(negedge clk);
    ref_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R10: outputs low in reset
    chk(!play0_tick && !play1_tick && !rec_tick, "R10",
        {play0_tick, play1_tick, rec_tick}, 0);

    for (int v = 0; v < NV; v++) begin
      fixed_sel = VECS[v].sel; div_n = VECS[v].n;
      follow_fixed = VECS[v].sync; ext_src = VECS[v].ext;
      {rec_en, play1_en, play0_en} = VECS[v].en;
      do_reset();
      chk(!play0_tick && !play1_tick && !rec_tick, "R10",
          {play0_tick, play1_tick, rec_tick}, 0);
      for (int p = 0; p < int'(VECS[v].pulses); p++) begin
        pulse_ref();
        idle();
      end
      idle();
      chk(c0 == int'(VECS[v].e0), "R1/R8 play0 count", c0, int'(VECS[v].e0));
      chk(c2 == int'(VECS[v].e2), "R2/R8 rec count",   c2, int'(VECS[v].e2));
      chk(c1 == int'(VECS[v].e1), "R3/R4/R5 play1 count", c1, int'(VECS[v].e1));
      if (VECS[v].en == 3'b111) begin
        if (VECS[v].sync)      chk(mis_fix == 0,  "R4 coincide", mis_fix, 0);
        else if (!VECS[v].ext) chk(mis_prog == 0, "R3 coincide", mis_prog, 0);
      end
    end

    // R6 / R9: exact cycle with period 2
    fixed_sel = 2'd3; div_n = 13'd0; follow_fixed = 0; ext_src = 0;
    {rec_en, play1_en, play0_en} = 3'b111;
    do_reset();
    pulse_ref();
    chk(!rec_tick, "R6 no tick after 1st pulse", rec_tick, 0);
    idle();
    pulse_ref();
    chk(rec_tick && play1_tick, "R6 tick after 2nd pulse", rec_tick, 1);
    idle();
    chk(!rec_tick && !play1_tick, "R9 one cycle", rec_tick, 0);

    // R7: reprogram divider mid-period (12 -> 2)
    div_n = 13'd10;
    do_reset();
    for (int p = 0; p < 5; p++) begin pulse_ref(); idle(); end
    div_n = 13'd0;
    for (int p = 0; p < 6; p++) begin pulse_ref(); idle(); end
    chk(c2 == 0, "R7 old period holds", c2, 0);
    pulse_ref();
    chk(rec_tick, "R7 tick at 12th pulse", rec_tick, 1);
    idle();
    pulse_ref(); idle(); pulse_ref(); idle();
    chk(c2 == 2, "R7 new period after boundary", c2, 2);

    // R7: fixed select change 32 -> 256 mid-period
    fixed_sel = 2'd3;
    do_reset();
    for (int p = 0; p < 10; p++) begin pulse_ref(); idle(); end
    fixed_sel = 2'd0;
    for (int p = 0; p < 22; p++) begin pulse_ref(); idle(); end
    chk(c0 == 1, "R7 fixed old period", c0, 1);

    // R8: phase kept while disabled, period 5
    div_n = 13'd3; rec_en = 1'b0;
    do_reset();
    for (int p = 0; p < 3; p++) begin pulse_ref(); idle(); end
    rec_en = 1'b1;
    pulse_ref(); idle();
    chk(c2 == 0, "R8 no early tick", c2, 0);
    pulse_ref();
    chk(rec_tick, "R8 phase kept", rec_tick, 1);
    idle();

    // R5: external strobe pass-through
    follow_fixed = 1'b0; ext_src = 1'b1; play1_en = 1'b1;
    do_reset();
    ext_tick = 1'b1;
    @(negedge clk);
    ext_tick = 1'b0;
    chk(play1_tick, "R5 ext tick passes", play1_tick, 1);
    idle();
    chk(!play1_tick, "R5 ext tick ends", play1_tick, 0);
    play1_en = 1'b0;
    ext_tick = 1'b1;
    @(negedge clk);
    ext_tick = 1'b0;
    chk(!play1_tick, "R8 ext gated", play1_tick, 0);
    idle();

    finish_run();
  end

endmodule